// File: doc/BRIEF.md
# Ones-Complement Checksum Engine with Incremental Update

The engine computes an Internet-style ones-complement checksum over a stream of data words. Words enter on a valid/ready port, and each carries a start flag and a last flag. A running sum is kept with the carry out of the top bit folded back into bit 0 on every cycle. When the last word of a packet has been taken, the engine presents the bitwise complement of that sum. The result stays on the output until the next packet starts.

A second, independent port revises a checksum that is already known when a single word of the covered data changes. It takes the old checksum, the old word and the replacement word under one strobe. Two cycles later it returns the revised checksum, without seeing any of the other words.

A byte-order input makes the stream path treat every word, and the result, with its two halves exchanged. The word width is a parameter, so a narrow build can be checked against small worked examples.

Top module: `ocsum_engine`

## Requirements
- R1: Words are summed in W-bit ones-complement arithmetic: a carry out of bit W-1 is added back into bit 0 (for W=16, 0xFFFF plus 0x0001 sums to 0x0001).
- R2: `sum_out` equals the bitwise complement of the ones-complement sum of every word from the word flagged start up to and including the word flagged last. The start flag discards any earlier sum.
- R3: `sum_valid` rises on the first clock edge after the last word is accepted. It stays high with `sum_out` unchanged while no word is accepted. It drops on the edge that accepts a start word that is not also last.
- R4: A word with both start and last set forms a one-word packet whose checksum is the complement of that word.
- R5: A packet whose sum is all ones (0xFFFF for W=16) yields a checksum of all zeros.
- R6: With `swap_en` high, each input word has its upper and lower halves exchanged before it is summed, and the complemented sum has its halves exchanged before output. Halves are bits [W-1:W/2] and [W/2-1:0].
- R7: With `swap_en` low, feeding every word with its halves exchanged gives the normal checksum with its halves exchanged.
- R8: For an update request with old checksum C, old word X and new word Y, `upd_res` equals the complement of the ones-complement sum of ~C, ~X and Y. `upd_res_valid` is high exactly on the second clock edge after `upd_valid` is sampled.
- R9: For data that is not all zeros and a new word that is not zero, the update result equals a full recomputation over the data with the word replaced.
- R10: An old checksum of all zeros and one of all ones, meaning the two encodings of zero, give the same update result.
- R11: With W=4, words 1101 and 0110 give checksum 1011. Replacing 1101 by 1011 gives checksum 1101 on both paths. Words 0111 and 1001 give 1110.
- R12: `in_ready`, `sum_valid` and `upd_res_valid` are low during reset. `in_ready` is high from the first edge after reset and stays high.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous active-high reset |
| swap_en | input | 1 | Exchange word halves on stream input and result |
| in_valid | input | 1 | Stream word present |
| in_ready | output | 1 | Engine accepts stream words |
| in_start | input | 1 | Word is the first of a packet |
| in_last | input | 1 | Word is the last of a packet |
| in_word | input | W | Stream data word |
| sum_valid | output | 1 | `sum_out` holds a finished checksum |
| sum_out | output | W | Packet checksum |
| upd_valid | input | 1 | Update request strobe |
| upd_old_csum | input | W | Checksum before the word change |
| upd_old_word | input | W | Word being replaced |
| upd_new_word | input | W | Replacement word |
| upd_res_valid | output | 1 | `upd_res` is valid |
| upd_res | output | W | Revised checksum |

## Verification
The bench targets the fold of the end-around carry, which a design that drops the carry gets wrong by one for 0xFFFF plus 0x0001. It also covers the all-ones sum, which a design that special-cases zero would turn into 0xFFFF. It replaces random words and compares the update path against a full recomputation, which exposes a wrong operand complement or a missing carry fold in the two-stage pipeline. It checks result hold and clear around the start flag, the two encodings of zero on the update port, and the half-exchange rules at both 16 and 4 bits, where a swap applied on only one side would leave the halves out of place.

// File: rtl/ocsum_pkg.sv
package ocsum_pkg;
  localparam int OCSUM_DEFAULT_W = 16;

  typedef enum logic {
    ORDER_NATIVE  = 1'b0,
    ORDER_SWAPPED = 1'b1
  } byte_order_e;
endpackage

// File: rtl/ocsum_adder.sv
// Ones-complement adder: carry out of the top bit re-enters at bit 0.
// The re-added carry can never produce a second carry.
module ocsum_adder #(
  parameter int W = 16
) (
  input  logic [W-1:0] a,
  input  logic [W-1:0] b,
  output logic [W-1:0] s
);
  logic [W:0] raw;
  assign raw = {1'b0, a} + {1'b0, b};
  assign s   = raw[W-1:0] + {{(W-1){1'b0}}, raw[W]};
endmodule

// File: rtl/ocsum_swap.sv
// Exchanges the two halves of a word when enabled (even widths only).
module ocsum_swap #(
  parameter int W = 16
) (
  input  logic         en,
  input  logic [W-1:0] d,
  output logic [W-1:0] q
);
  generate
    if (W % 2 == 0) begin : g_even
      localparam int H = W / 2;
      assign q = en ? {d[H-1:0], d[W-1:H]} : d;
    end else begin : g_odd
      assign q = d;
    end
  endgenerate
endmodule

// File: rtl/ocsum_stream.sv
module ocsum_stream
  import ocsum_pkg::*;
#(
  parameter int W = 16
) (
  input  logic        clk,
  input  logic        rst,
  input  byte_order_e order,
  input  logic        in_valid,
  input  logic        in_start,
  input  logic        in_last,
  input  logic [W-1:0] in_word,
  output logic        in_ready,
  output logic        sum_valid,
  output logic [W-1:0] sum_out
);
  logic         ready_q;
  logic         take;
  logic         swap;
  logic [W-1:0] word_n;
  logic [W-1:0] acc_q;
  logic [W-1:0] base;
  logic [W-1:0] acc_next;
  logic [W-1:0] csum_n;
  logic [W-1:0] csum_o;
  logic         valid_q;
  logic [W-1:0] out_q;

  assign swap = (order == ORDER_SWAPPED);
  assign take = in_valid & ready_q;

  ocsum_swap #(.W(W)) u_swap_in (.en(swap), .d(in_word), .q(word_n));

  assign base = in_start ? '0 : acc_q;

  ocsum_adder #(.W(W)) u_add (.a(base), .b(word_n), .s(acc_next));

  assign csum_n = ~acc_next;

  ocsum_swap #(.W(W)) u_swap_out (.en(swap), .d(csum_n), .q(csum_o));

  always_ff @(posedge clk) begin
    if (rst) begin
      ready_q <= 1'b0;
      acc_q   <= '0;
      valid_q <= 1'b0;
      out_q   <= '0;
    end else begin
      ready_q <= 1'b1;
      if (take) begin
        acc_q <= acc_next;
        if (in_last) begin
          valid_q <= 1'b1;
          out_q   <= csum_o;
        end else if (in_start) begin
          valid_q <= 1'b0;
        end
      end
    end
  end

  assign in_ready  = ready_q;
  assign sum_valid = valid_q;
  assign sum_out   = out_q;
endmodule

// File: rtl/ocsum_update.sv
// Two-stage incremental revision: new = ~( ~old + ~x + y ).
module ocsum_update #(
  parameter int W = 16
) (
  input  logic         clk,
  input  logic         rst,
  input  logic         upd_valid,
  input  logic [W-1:0] old_csum,
  input  logic [W-1:0] old_word,
  input  logic [W-1:0] new_word,
  output logic         res_valid,
  output logic [W-1:0] res
);
  logic [W-1:0] delta;
  logic         s1_valid;
  logic [W-1:0] s1_sum;
  logic [W-1:0] s1_delta;
  logic [W-1:0] total;
  logic         s2_valid;
  logic [W-1:0] s2_res;

  ocsum_adder #(.W(W)) u_delta (.a(~old_word), .b(new_word), .s(delta));
  ocsum_adder #(.W(W)) u_total (.a(s1_sum), .b(s1_delta), .s(total));

  always_ff @(posedge clk) begin
    if (rst) begin
      s1_valid <= 1'b0;
      s1_sum   <= '0;
      s1_delta <= '0;
      s2_valid <= 1'b0;
      s2_res   <= '0;
    end else begin
      s1_valid <= upd_valid;
      s2_valid <= s1_valid;
      if (upd_valid) begin
        s1_sum   <= ~old_csum;
        s1_delta <= delta;
      end
      if (s1_valid) begin
        s2_res <= ~total;
      end
    end
  end

  assign res_valid = s2_valid;
  assign res       = s2_res;
endmodule

// File: rtl/ocsum_engine.sv
module ocsum_engine
  import ocsum_pkg::*;
#(
  parameter int W = OCSUM_DEFAULT_W
) (
  input  logic         clk,
  input  logic         rst,
  input  logic         swap_en,
  input  logic         in_valid,
  output logic         in_ready,
  input  logic         in_start,
  input  logic         in_last,
  input  logic [W-1:0] in_word,
  output logic         sum_valid,
  output logic [W-1:0] sum_out,
  input  logic         upd_valid,
  input  logic [W-1:0] upd_old_csum,
  input  logic [W-1:0] upd_old_word,
  input  logic [W-1:0] upd_new_word,
  output logic         upd_res_valid,
  output logic [W-1:0] upd_res
);
  byte_order_e order;
  assign order = swap_en ? ORDER_SWAPPED : ORDER_NATIVE;

  ocsum_stream #(.W(W)) u_stream (
    .clk(clk), .rst(rst), .order(order),
    .in_valid(in_valid), .in_start(in_start), .in_last(in_last),
    .in_word(in_word), .in_ready(in_ready),
    .sum_valid(sum_valid), .sum_out(sum_out)
  );

  ocsum_update #(.W(W)) u_update (
    .clk(clk), .rst(rst), .upd_valid(upd_valid),
    .old_csum(upd_old_csum), .old_word(upd_old_word), .new_word(upd_new_word),
    .res_valid(upd_res_valid), .res(upd_res)
  );
endmodule

// File: rtl/ocsum_engine_chk.sv
module ocsum_engine_chk #(
  parameter int W = 16
) (
  input logic         clk,
  input logic         rst,
  input logic         in_valid,
  input logic         in_ready,
  input logic         in_start,
  input logic         in_last,
  input logic         sum_valid,
  input logic [W-1:0] sum_out,
  input logic         upd_valid,
  input logic         upd_res_valid
);
  p_valid_after_last_r3: assert property (@(posedge clk) disable iff (rst)
    (in_valid && in_ready && in_last) |=> sum_valid);

  p_hold_idle_r3: assert property (@(posedge clk) disable iff (rst)
    (sum_valid && !in_valid) |=> (sum_valid && $stable(sum_out)));

  p_start_clears_r3: assert property (@(posedge clk) disable iff (rst)
    (in_valid && in_ready && in_start && !in_last) |=> !sum_valid);

  p_upd_latency_r8: assert property (@(posedge clk) disable iff (rst)
    upd_valid |=> ##1 upd_res_valid);

  p_upd_quiet_r8: assert property (@(posedge clk) disable iff (rst)
    !upd_valid |=> ##1 !upd_res_valid);

  p_ready_stays_r12: assert property (@(posedge clk) disable iff (rst)
    in_ready |=> in_ready);
endmodule

bind ocsum_engine ocsum_engine_chk #(.W(W)) u_chk (
  .clk(clk), .rst(rst), .in_valid(in_valid), .in_ready(in_ready),
  .in_start(in_start), .in_last(in_last), .sum_valid(sum_valid),
  .sum_out(sum_out), .upd_valid(upd_valid), .upd_res_valid(upd_res_valid)
);

// File: tb/ocsum_engine_test.sv
`timescale 1ns/1ps
module ocsum_engine_test;
  logic clk = 1'b0;
  logic rst = 1'b1;
  always #4 clk = ~clk;

  // 16-bit instance
  logic        swap_en = 0, in_valid = 0, in_start = 0, in_last = 0;
  logic [15:0] in_word = 0;
  logic        in_ready, sum_valid;
  logic [15:0] sum_out;
  logic        upd_valid = 0;
  logic [15:0] upd_old_csum = 0, upd_old_word = 0, upd_new_word = 0;
  logic        upd_res_valid;
  logic [15:0] upd_res;

  ocsum_engine #(.W(16)) uut (
    .clk(clk), .rst(rst), .swap_en(swap_en), .in_valid(in_valid), .in_ready(in_ready),
    .in_start(in_start), .in_last(in_last), .in_word(in_word),
    .sum_valid(sum_valid), .sum_out(sum_out), .upd_valid(upd_valid),
    .upd_old_csum(upd_old_csum), .upd_old_word(upd_old_word), .upd_new_word(upd_new_word),
    .upd_res_valid(upd_res_valid), .upd_res(upd_res)
  );

  // 4-bit instance
  logic       n_swap = 0, n_valid = 0, n_start = 0, n_last = 0;
  logic [3:0] n_word = 0;
  logic       n_ready, n_sum_valid;
  logic [3:0] n_sum;
  logic       n_upd = 0;
  logic [3:0] n_oc = 0, n_ow = 0, n_nw = 0;
  logic       n_res_valid;
  logic [3:0] n_res;

  ocsum_engine #(.W(4)) uut4 (
    .clk(clk), .rst(rst), .swap_en(n_swap), .in_valid(n_valid), .in_ready(n_ready),
    .in_start(n_start), .in_last(n_last), .in_word(n_word),
    .sum_valid(n_sum_valid), .sum_out(n_sum), .upd_valid(n_upd),
    .upd_old_csum(n_oc), .upd_old_word(n_ow), .upd_new_word(n_nw),
    .upd_res_valid(n_res_valid), .upd_res(n_res)
  );

  int checks = 0;
  int errors = 0;
  logic [15:0] pkt [16];

  function automatic logic [15:0] oadd(input logic [15:0] a, input logic [15:0] b);
    logic [16:0] t;
    t = {1'b0, a} + {1'b0, b};
    return t[15:0] + {15'd0, t[16]};
  endfunction

  function automatic logic [15:0] swp(input logic [15:0] a);
    return {a[7:0], a[15:8]};
  endfunction

  function automatic logic [15:0] ref_csum(input int n, input bit sw);
    logic [15:0] s = 16'h0000;
    for (int i = 0; i < n; i++) s = oadd(s, sw ? swp(pkt[i]) : pkt[i]);
    return ~s;
  endfunction

  task automatic chk(input string req, input logic [15:0] act, input logic [15:0] exp);
    checks++;
    if (act !== exp) begin
      errors++;
      $display("FAIL %s: actual %h expected %h", req, act, exp);
    end
  endtask

  task automatic send_pkt(input int n, input bit sw, input bit sw_words);
    for (int i = 0; i < n; i++) begin
      @(negedge clk);
      swap_en  = sw;
      in_valid = 1;
      in_start = (i == 0);
      in_last  = (i == n - 1);
      in_word  = sw_words ? swp(pkt[i]) : pkt[i];
    end
    @(negedge clk);
    in_valid = 0; in_start = 0; in_last = 0;
  endtask

  task automatic do_update(input logic [15:0] c, input logic [15:0] x, input logic [15:0] y,
                           output logic [15:0] r);
    @(negedge clk);
    upd_valid = 1; upd_old_csum = c; upd_old_word = x; upd_new_word = y;
    @(negedge clk);
    upd_valid = 0;
    chk("R8 valid not early", {15'd0, upd_res_valid}, 16'd0);
    @(negedge clk);
    chk("R8 valid at two cycles", {15'd0, upd_res_valid}, 16'd1);
    r = upd_res;
  endtask

  task automatic t_reset;
    @(negedge clk);
    chk("R12 ready low in reset", {15'd0, in_ready}, 16'd0);
    chk("R12 sum_valid low in reset", {15'd0, sum_valid}, 16'd0);
    chk("R12 upd_res_valid low in reset", {15'd0, upd_res_valid}, 16'd0);
    rst = 0;
    @(negedge clk);
    chk("R12 ready after reset", {15'd0, in_ready}, 16'd1);
  endtask

  task automatic t_carry;
    pkt[0] = 16'hFFFF; pkt[1] = 16'h0001;
    send_pkt(2, 0, 0);
    chk("R1 end-around carry", sum_out, 16'hFFFE);
    chk("R3 valid after last", {15'd0, sum_valid}, 16'd1);
  endtask

  task automatic t_header;
    logic [15:0] v [10] = '{16'h4500, 16'h0073, 16'h0000, 16'h4000, 16'h4011,
                            16'h0000, 16'hc0a8, 16'h0001, 16'hc0a8, 16'h00c7};
    for (int i = 0; i < 10; i++) pkt[i] = v[i];
    send_pkt(10, 0, 0);
    chk("R2 ten-word packet", sum_out, 16'hb861);
    chk("R2 ten-word model", sum_out, ref_csum(10, 0));
  endtask

  task automatic t_hold;
    logic [15:0] held;
    held = sum_out;
    repeat (3) @(negedge clk);
    chk("R3 valid held idle", {15'd0, sum_valid}, 16'd1);
    chk("R3 value held idle", sum_out, held);
    @(negedge clk);
    in_valid = 1; in_start = 1; in_last = 0; in_word = 16'h1111;
    @(negedge clk);
    in_valid = 0; in_start = 0;
    chk("R3 start clears valid", {15'd0, sum_valid}, 16'd0);
    @(negedge clk);
    in_valid = 1; in_last = 1; in_word = 16'h2222;
    @(negedge clk);
    in_valid = 0; in_last = 0;
    chk("R2 start discards old sum", sum_out, ~16'h3333);
  endtask

  task automatic t_single;
    pkt[0] = 16'h1234;
    send_pkt(1, 0, 0);
    chk("R4 single word", sum_out, 16'hEDCB);
  endtask

  task automatic t_allones;
    pkt[0] = 16'hF0F0; pkt[1] = 16'h0F0F;
    send_pkt(2, 0, 0);
    chk("R5 all-ones sum gives zero", sum_out, 16'h0000);
  endtask

  task automatic t_swap;
    for (int k = 0; k < 4; k++) begin
      for (int i = 0; i < 6; i++) pkt[i] = $urandom | 16'h0101;
      send_pkt(6, 1, 0);
      chk("R6 swap mode", sum_out, swp(ref_csum(6, 1)));
      send_pkt(6, 0, 1);
      chk("R7 byte-order independence", sum_out, swp(ref_csum(6, 0)));
    end
  endtask

  task automatic t_update_direct;
    logic [15:0] r;
    do_update(16'hB861, 16'h4011, 16'h3F11, r);
    chk("R8 update value", r, ~oadd(oadd(~16'hB861, ~16'h4011), 16'h3F11));
  endtask

  task automatic t_recompute;
    logic [15:0] c_old, c_new, r, x, y;
    for (int k = 0; k < 12; k++) begin
      for (int i = 0; i < 8; i++) pkt[i] = $urandom;
      pkt[0] = pkt[0] | 16'h0001;
      send_pkt(8, 0, 0);
      c_old = sum_out;
      begin
        int idx = k % 8;
        x = pkt[idx];
        y = $urandom | 16'h0010;
        pkt[idx] = y;
        pkt[0] = pkt[0] | 16'h0001;
        y = pkt[idx];
      end
      do_update(c_old, x, y, r);
      send_pkt(8, 0, 0);
      c_new = sum_out;
      chk("R9 update equals recompute", r, c_new);
      chk("R9 recompute model", c_new, ref_csum(8, 0));
    end
  endtask

  task automatic t_negzero;
    logic [15:0] r0, r1;
    do_update(16'h0000, 16'h1234, 16'h5678, r0);
    do_update(16'hFFFF, 16'h1234, 16'h5678, r1);
    chk("R10 zero encodings agree", r0, r1);
    chk("R10 value", r0, ~oadd(16'hEDCB, 16'h5678));
  endtask

  task automatic n_send2(input logic [3:0] a, input logic [3:0] b);
    @(negedge clk);
    n_valid = 1; n_start = 1; n_last = 0; n_word = a;
    @(negedge clk);
    n_start = 0; n_last = 1; n_word = b;
    @(negedge clk);
    n_valid = 0; n_last = 0;
  endtask

  task automatic t_narrow;
    n_send2(4'b1101, 4'b0110);
    chk("R11 narrow x,z", {12'd0, n_sum}, 16'b1011);
    n_send2(4'b1011, 4'b0110);
    chk("R11 narrow y,z", {12'd0, n_sum}, 16'b1101);
    @(negedge clk);
    n_upd = 1; n_oc = 4'b1011; n_ow = 4'b1101; n_nw = 4'b1011;
    @(negedge clk);
    n_upd = 0;
    @(negedge clk);
    chk("R11 narrow update valid", {15'd0, n_res_valid}, 16'd1);
    chk("R11 narrow update", {12'd0, n_res}, 16'b1101);
    n_send2(4'b0111, 4'b1001);
    chk("R11 narrow swapped", {12'd0, n_sum}, 16'b1110);
  endtask

  initial begin
    repeat (100000) @(posedge clk);
    checks++; errors++;
    $display("FAIL watchdog: actual timeout expected completion");
    $display("Simulation finished: %0d checks, %0d errors", checks, errors);
    $finish;
  end

  initial begin
    repeat (2) @(negedge clk);
    t_reset;
    t_carry;
    t_header;
    t_hold;
    t_single;
    t_allones;
    t_swap;
    t_update_direct;
    t_recompute;
    t_negzero;
    t_narrow;
    repeat (2) @(negedge clk);
    $display("Simulation finished: %0d checks, %0d errors", checks, errors);
    $finish;
  end
endmodule